// File: doc/BRIEF.md
# Tile pattern dirty tracker

This block keeps track of which cached tile patterns have gone stale after video memory word writes. Each write notification carries a word address and a flag that says whether the stored word actually changed. For a changed write the block derives two pattern indices from the address, one for the background pattern cache and one for the sprite pattern cache. In each index's row bitmask it sets the bit for the row that was touched.

Each of the two caches also has a compact pending list. An index is appended to its list only on the write that takes its mask from zero to non-zero, so every index appears at most once. A cache refill engine pops entries from the head of a list. Each pop hands over the index together with its accumulated row mask and clears that mask, so the index can be listed again by a later write. Because of this, a consumer only visits patterns that were really touched.

Top module: `tile_dirty_tracker`

## Requirements
- R1: After reset both masks tables are clear, both pending lists are empty, bg_count and obj_count read 0, and bg_valid and obj_valid are low.
- R2: A cycle with wr_en low, or with wr_en high and wr_changed low, changes no mask, no list and no count.
- R3: The background index of a changed write is wr_addr[14:4], which gives 2048 background entries.
- R4: The background mask is 8 bits wide. A changed write sets bit wr_addr[2:0] of it, and wr_addr[3] has no effect on the background mask.
- R5: The sprite index of a changed write is wr_addr[14:6], which gives 512 sprite entries.
- R6: The sprite mask is 16 bits wide, and a changed write sets bit wr_addr[3:0] of it.
- R7: An index is appended to its list, and its count rises by one, only when its mask was zero before the write. Further writes to a listed index OR more bits into its mask without adding an entry. A listed index always shows a non-zero mask.
- R8: When the list is non-empty, the head entry is shown on *_idx and *_mask in append order. A pop removes that entry, clears its mask, and lowers the count by one in the next cycle.
- R9: After an index has been popped, a later changed write to it lists it again at the tail.
- R10: When a pop and a changed write hit the same index in the same cycle, the pop returns the old mask. The index is then listed again holding only the new row bit.
- R11: A pop while the list is empty is ignored.
- R12: A list holds every index at the same time without overflow: bg_count can reach 2048 and obj_count can reach 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write notification valid |
| wr_changed | input | 1 | Written word differs from previous content |
| wr_addr | input | 15 | Word address of the write |
| bg_pop | input | 1 | Remove head of background list |
| bg_valid | output | 1 | Background list non-empty |
| bg_idx | output | 11 | Background index at list head |
| bg_mask | output | 8 | Row mask of head background index |
| bg_count | output | 12 | Background list occupancy |
| obj_pop | input | 1 | Remove head of sprite list |
| obj_valid | output | 1 | Sprite list non-empty |
| obj_idx | output | 9 | Sprite index at list head |
| obj_mask | output | 16 | Row mask of head sprite index |
| obj_count | output | 10 | Sprite list occupancy |

## Verification
The address patterns include writes that share a background index but differ in address bit 3, and writes that fall in one sprite index but hit separate rows. These show whether the two address mappings are applied independently and whether bits accumulate without duplicate list entries. Writes with the changed flag low, pops on empty lists and a pop that collides with a write to the same index separate the ignore cases from the priority rule. A full sweep over every background index confirms append order at full occupancy.

// File: rtl/tile_dirty_tracker.sv
module tile_dirty_tracker #(
  parameter int ADDR_W     = 15,
  parameter int BG_LSB     = 4,
  parameter int BG_SEL_W   = 3,
  parameter int OBJ_LSB    = 6,
  parameter int OBJ_SEL_W  = 4,
  localparam int BG_IW     = ADDR_W - BG_LSB,
  localparam int BG_MW     = 1 << BG_SEL_W,
  localparam int OBJ_IW    = ADDR_W - OBJ_LSB,
  localparam int OBJ_MW    = 1 << OBJ_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_changed,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              bg_pop,
  output logic              bg_valid,
  output logic [BG_IW-1:0]  bg_idx,
  output logic [BG_MW-1:0]  bg_mask,
  output logic [BG_IW:0]    bg_count,
  input  logic              obj_pop,
  output logic              obj_valid,
  output logic [OBJ_IW-1:0] obj_idx,
  output logic [OBJ_MW-1:0] obj_mask,
  output logic [OBJ_IW:0]   obj_count
);
  localparam int BG_N  = 1 << BG_IW;
  localparam int OBJ_N = 1 << OBJ_IW;

  wire mark = wr_en & wr_changed;

  // background side
  logic [BG_MW-1:0] bg_mtab [BG_N];
  logic [BG_IW-1:0] bg_list [BG_N];
  logic [BG_IW-1:0] bg_head, bg_tail;

  wire [BG_IW-1:0] bg_widx = wr_addr[ADDR_W-1:BG_LSB];
  wire [BG_MW-1:0] bg_bit  = BG_MW'(1) << wr_addr[BG_SEL_W-1:0];
  wire             bg_take = bg_pop & bg_valid;
  wire [BG_MW-1:0] bg_prev = (bg_take && bg_idx == bg_widx) ? '0 : bg_mtab[bg_widx];
  wire             bg_app  = mark & (bg_prev == '0);

  assign bg_valid = bg_count != '0;
  assign bg_idx   = bg_list[bg_head];
  assign bg_mask  = bg_mtab[bg_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BG_N; i++) begin
        bg_mtab[i] <= '0;
        bg_list[i] <= '0;
      end
      bg_head  <= '0;
      bg_tail  <= '0;
      bg_count <= '0;
    end else begin
      if (bg_take) begin
        bg_mtab[bg_idx] <= '0;
        bg_head <= bg_head + 1'b1;
      end
      if (mark) bg_mtab[bg_widx] <= bg_prev | bg_bit;
      if (bg_app) begin
        bg_list[bg_tail] <= bg_widx;
        bg_tail <= bg_tail + 1'b1;
      end
      bg_count <= bg_count + (BG_IW+1)'(bg_app) - (BG_IW+1)'(bg_take);
    end
  end

  // sprite side
  logic [OBJ_MW-1:0] obj_mtab [OBJ_N];
  logic [OBJ_IW-1:0] obj_list [OBJ_N];
  logic [OBJ_IW-1:0] obj_head, obj_tail;

  wire [OBJ_IW-1:0] obj_widx = wr_addr[ADDR_W-1:OBJ_LSB];
  wire [OBJ_MW-1:0] obj_bit  = OBJ_MW'(1) << wr_addr[OBJ_SEL_W-1:0];
  wire              obj_take = obj_pop & obj_valid;
  wire [OBJ_MW-1:0] obj_prev = (obj_take && obj_idx == obj_widx) ? '0 : obj_mtab[obj_widx];
  wire              obj_app  = mark & (obj_prev == '0);

  assign obj_valid = obj_count != '0;
  assign obj_idx   = obj_list[obj_head];
  assign obj_mask  = obj_mtab[obj_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < OBJ_N; i++) begin
        obj_mtab[i] <= '0;
        obj_list[i] <= '0;
      end
      obj_head  <= '0;
      obj_tail  <= '0;
      obj_count <= '0;
    end else begin
      if (obj_take) begin
        obj_mtab[obj_idx] <= '0;
        obj_head <= obj_head + 1'b1;
      end
      if (mark) obj_mtab[obj_widx] <= obj_prev | obj_bit;
      if (obj_app) begin
        obj_list[obj_tail] <= obj_widx;
        obj_tail <= obj_tail + 1'b1;
      end
      obj_count <= obj_count + (OBJ_IW+1)'(obj_app) - (OBJ_IW+1)'(obj_take);
    end
  end
endmodule

// File: rtl/tile_dirty_tracker_chk.sv
module tile_dirty_tracker_chk #(
  parameter int BG_IW  = 11,
  parameter int BG_MW  = 8,
  parameter int OBJ_IW = 9,
  parameter int OBJ_MW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_changed,
  input logic              bg_pop,
  input logic              bg_valid,
  input logic [BG_MW-1:0]  bg_mask,
  input logic [BG_IW:0]    bg_count,
  input logic              obj_pop,
  input logic              obj_valid,
  input logic [OBJ_MW-1:0] obj_mask,
  input logic [OBJ_IW:0]   obj_count
);
  wire mk = wr_en & wr_changed;

  // R2
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mk && !bg_pop && !obj_pop) |=> ($stable(bg_count) && $stable(obj_count)));

  // R7
  bg_listed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bg_valid |-> bg_mask != '0);

  // R7
  obj_listed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    obj_valid |-> obj_mask != '0);

  // R8
  bg_pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_pop && bg_valid && !mk) |=> bg_count == $past(bg_count) - 1'b1);

  // R11
  obj_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_pop && !obj_valid && !mk) |=> obj_count == '0);

  // R12
  bg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bg_count <= (BG_IW+1)'(1 << BG_IW));
endmodule

bind tile_dirty_tracker tile_dirty_tracker_chk #(
  .BG_IW(BG_IW), .BG_MW(BG_MW), .OBJ_IW(OBJ_IW), .OBJ_MW(OBJ_MW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_changed(wr_changed),
  .bg_pop(bg_pop), .bg_valid(bg_valid), .bg_mask(bg_mask), .bg_count(bg_count),
  .obj_pop(obj_pop), .obj_valid(obj_valid), .obj_mask(obj_mask), .obj_count(obj_count)
);

// File: tb/tb_tile_dirty_tracker.sv
module tb_tile_dirty_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_changed = 0;
  logic [14:0] wr_addr = '0;
  logic bg_pop = 0, obj_pop = 0;
  logic bg_valid, obj_valid;
  logic [10:0] bg_idx;
  logic [7:0] bg_mask;
  logic [11:0] bg_count;
  logic [8:0] obj_idx;
  logic [15:0] obj_mask;
  logic [9:0] obj_count;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_dirty_tracker dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_changed(wr_changed), .wr_addr(wr_addr),
    .bg_pop(bg_pop), .bg_valid(bg_valid), .bg_idx(bg_idx), .bg_mask(bg_mask), .bg_count(bg_count),
    .obj_pop(obj_pop), .obj_valid(obj_valid), .obj_idx(obj_idx), .obj_mask(obj_mask),
    .obj_count(obj_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [14:0] a, input logic ch = 1);
    wr_en = 1; wr_changed = ch; wr_addr = a;
    @(negedge clk);
    wr_en = 0; wr_changed = 0;
  endtask

  task automatic pop_both(input logic pb, input logic po);
    bg_pop = pb; obj_pop = po;
    @(negedge clk);
    bg_pop = 0; obj_pop = 0;
  endtask

  task automatic t_reset();
    do_reset();
    wr(15'h0100);
    do_reset();
    chk("R1 bg_count", bg_count, 0);
    chk("R1 obj_count", obj_count, 0);
    chk("R1 valids", {bg_valid, obj_valid}, 0);
  endtask

  task automatic t_ignore();
    do_reset();
    wr(15'h0234, 0);
    wr_addr = 15'h0444; @(negedge clk);
    chk("R2 bg_count", bg_count, 0);
    chk("R2 obj_count", obj_count, 0);
    chk("R2 valid", {bg_valid, obj_valid}, 0);
  endtask

  task automatic t_map_order();
    do_reset();
    wr(15'h1235);
    wr(15'h0010);
    wr(15'h123A);
    chk("R7 bg_count", bg_count, 2);
    chk("R7 obj_count", obj_count, 2);
    chk("R3 bg_idx head", bg_idx, 11'h123);
    chk("R4 bg_mask bits 5,2", bg_mask, 8'h24);
    chk("R5 obj_idx head", obj_idx, 9'h048);
    chk("R6 obj_mask bits 10,5", obj_mask, 16'h0420);
    pop_both(1, 1);
    chk("R8 bg second idx", bg_idx, 11'h001);
    chk("R8 bg second mask", bg_mask, 8'h01);
    chk("R8 obj second idx", obj_idx, 9'h000);
    chk("R8 obj second mask", obj_mask, 16'h0001);
    chk("R8 bg_count after pop", bg_count, 1);
    pop_both(1, 1);
    chk("R8 empty", {bg_valid, obj_valid}, 0);
    pop_both(1, 1);
    chk("R11 bg_count", bg_count, 0);
    chk("R11 obj_count", obj_count, 0);
    wr(15'h1230);
    chk("R9 relist bg idx", bg_idx, 11'h123);
    chk("R9 relist bg mask", bg_mask, 8'h01);
    chk("R9 relist bg count", bg_count, 1);
  endtask

  task automatic t_collide();
    do_reset();
    wr(15'h0560);
    chk("R10 pre mask", bg_mask, 8'h01);
    wr_en = 1; wr_changed = 1; wr_addr = 15'h0565; bg_pop = 1;
    @(negedge clk);
    wr_en = 0; wr_changed = 0; bg_pop = 0;
    chk("R10 bg_count", bg_count, 1);
    chk("R10 bg idx", bg_idx, 11'h056);
    chk("R10 bg mask new bit only", bg_mask, 8'h20);
    chk("R10 obj mask merged", obj_mask, 16'h0021);
    chk("R10 obj_count", obj_count, 1);
  endtask

  task automatic t_full();
    int errs;
    do_reset();
    for (int i = 0; i < 2048; i++) wr(15'(i << 4));
    chk("R12 bg full count", bg_count, 2048);
    chk("R12 obj full count", obj_count, 512);
    errs = 0;
    for (int i = 0; i < 2048; i++) begin
      if (bg_idx !== 11'(i) || bg_mask !== 8'h01) errs++;
      pop_both(1, 0);
    end
    chk("R12 bg drain order errors", errs, 0);
    errs = 0;
    for (int i = 0; i < 512; i++) begin
      if (obj_idx !== 9'(i) || obj_mask !== 16'h0001) errs++;
      pop_both(0, 1);
    end
    chk("R12 obj drain order errors", errs, 0);
    chk("R12 drained", {bg_count, 2'b00, obj_count}, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_ignore();
        t_map_order();
        t_collide();
        t_full();
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule